// File: doc/BRIEF.md
# Lexicographic Nine-Valued Vector Comparator

This block orders two vectors of nine-valued logic symbols the way a dictionary orders words. Each operand carries its own length, from zero up to the parameter `N`. Element 0 is the leftmost and most significant position. The block scans from the left. The first position where the operands disagree decides the outcome. If one operand runs out before any disagreement, the shorter one ranks lower.

The symbol order comes from a fixed collating sequence, not from a numeric value. The block drives one-hot less-than, equal and greater-than flags and a flag for illegal symbol codes.

The comparison itself is purely combinational. When `REG_OUT` is 1, which is the default, one register stage follows it and adds one cycle of latency.

Top module: `lexcmp_top`

## Requirements
- R1: Symbols are 4-bit codes ranked by value: U=0, X=1, '0'=2, '1'=3, W=4, L=5, H=6, Z=7, don't-care=8. Element i of an operand sits at bits [(N-1-i)*4 +: 4] of its vector, so element 0 occupies the top nibble.
- R2: Positions are examined from element 0 upward, and the first position where the operands differ decides lt or gt.
- R3: When the shorter operand equals the leading part of the longer one, the shorter operand is less. An empty operand is less than any non-empty one.
- R4: A shorter operand ranks higher when an earlier position is larger. For example, "11" compares greater than "101".
- R5: eq is high only when both lengths match and every element inside that length is identical. Two empty operands are equal.
- R6: Elements at positions at or beyond an operand's length have no effect on any output. A length above N acts as N.
- R7: bad is high exactly when some element inside an operand's length has a code of 9 to 15. While bad is high, lt, eq and gt carry no meaning.
- R8: While bad is low, exactly one of lt, eq and gt is high.
- R9: For equal lengths and only '0' and '1' elements, the result matches an unsigned comparison of the binary numbers read left to right.
- R10: With REG_OUT=1, the outputs follow the inputs after one rising clock edge. A synchronous active-high reset sets lt=0, eq=1, gt=0 and bad=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| len_a | input | $clog2(N+1) | Element count of operand A |
| len_b | input | $clog2(N+1) | Element count of operand B |
| vec_a | input | 4*N | Operand A symbols, element 0 in the top nibble |
| vec_b | input | 4*N | Operand B symbols, element 0 in the top nibble |
| lt | output | 1 | A orders below B |
| eq | output | 1 | A and B are identical |
| gt | output | 1 | A orders above B |
| bad | output | 1 | An illegal code lies inside a length |

## Verification
Two things can happen in the same cycle: a length boundary can decide the order, and an element can sit just beyond a length. Cases are built so that a whole operand matches the prefix of the other. The slots beyond each length are filled with illegal codes or with the lowest symbol, U.

Such a case passes only if bad stays low and the shorter side ranks below. An extra U must still make the longer operand larger. Garbage beyond both lengths must still leave eq high.

// File: rtl/lexcmp_pkg.sv
package lexcmp_pkg;

    localparam int SYM_W     = 4;
    localparam int SYM_COUNT = 9;

    typedef logic [SYM_W-1:0] sym_t;

    // Outcome of one position: no decision, A below B, or A above B
    typedef enum logic [1:0] {
        STEP_TIE    = 2'd0,
        STEP_A_LOW  = 2'd1,
        STEP_A_HIGH = 2'd2
    } step_t;

    typedef struct packed {
        logic lt;
        logic eq;
        logic gt;
        logic bad;
    } verdict_t;

    localparam verdict_t VERDICT_IDLE = '{lt: 1'b0, eq: 1'b1, gt: 1'b0, bad: 1'b0};

    function automatic logic sym_legal(input sym_t s);
        return s < sym_t'(SYM_COUNT);
    endfunction

    // Codes equal their rank in the collating sequence
    function automatic step_t order_syms(input sym_t a, input sym_t b);
        if (a < b)      return STEP_A_LOW;
        else if (a > b) return STEP_A_HIGH;
        else            return STEP_TIE;
    endfunction

endpackage

// File: rtl/lexcmp_cell.sv
module lexcmp_cell
    import lexcmp_pkg::*;
#(
    parameter int POS = 0,
    parameter int LW  = 4
) (
    input  logic [LW-1:0] len_a,
    input  logic [LW-1:0] len_b,
    input  sym_t          sym_a,
    input  sym_t          sym_b,
    output step_t         step,
    output logic          bad
);

    logic live_a;
    logic live_b;

    assign live_a = len_a > LW'(POS);
    assign live_b = len_b > LW'(POS);

    // End of an operand ranks below every symbol
    always_comb begin
        unique case ({live_a, live_b})
            2'b11:   step = order_syms(sym_a, sym_b);
            2'b10:   step = STEP_A_HIGH;
            2'b01:   step = STEP_A_LOW;
            default: step = STEP_TIE;
        endcase
    end

    assign bad = (live_a && !sym_legal(sym_a)) || (live_b && !sym_legal(sym_b));

endmodule

// File: rtl/lexcmp_prio.sv
module lexcmp_prio
    import lexcmp_pkg::*;
#(
    parameter int N = 8
) (
    input  step_t      steps [N],
    input  logic [N-1:0] bads,
    output verdict_t   vd
);

    step_t first;

    // Lowest index wins: scan from the right so the leftmost decision stays
    always_comb begin
        first = STEP_TIE;
        for (int i = N - 1; i >= 0; i--) begin
            if (steps[i] != STEP_TIE) first = steps[i];
        end
    end

    assign vd.lt  = (first == STEP_A_LOW);
    assign vd.gt  = (first == STEP_A_HIGH);
    assign vd.eq  = (first == STEP_TIE);
    assign vd.bad = |bads;

endmodule

// File: rtl/lexcmp_top.sv
module lexcmp_top
    import lexcmp_pkg::*;
#(
    parameter int N       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [$clog2(N+1)-1:0]        len_a,
    input  logic [$clog2(N+1)-1:0]        len_b,
    input  logic [N*lexcmp_pkg::SYM_W-1:0] vec_a,
    input  logic [N*lexcmp_pkg::SYM_W-1:0] vec_b,
    output logic                          lt,
    output logic                          eq,
    output logic                          gt,
    output logic                          bad
);

    localparam int LW = $clog2(N + 1);

    step_t        steps [N];
    logic [N-1:0] bads;
    verdict_t     vd;
    verdict_t     vq;

    for (genvar g = 0; g < N; g++) begin : g_pos
        lexcmp_cell #(.POS(g), .LW(LW)) u_cell (
            .len_a (len_a),
            .len_b (len_b),
            .sym_a (vec_a[(N-1-g)*SYM_W +: SYM_W]),
            .sym_b (vec_b[(N-1-g)*SYM_W +: SYM_W]),
            .step  (steps[g]),
            .bad   (bads[g])
        );
    end

    lexcmp_prio #(.N(N)) u_prio (
        .steps (steps),
        .bads  (bads),
        .vd    (vd)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) vq <= VERDICT_IDLE;
            else     vq <= vd;
        end
    end else begin : g_comb
        assign vq = vd;
    end

    assign lt  = vq.lt;
    assign eq  = vq.eq;
    assign gt  = vq.gt;
    assign bad = vq.bad;

    // R8
    verdict_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        !vd.bad |-> $countones({vd.lt, vd.eq, vd.gt}) == 1);

    // R8
    port_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        !bad |-> $countones({lt, eq, gt}) == 1);

    // R5
    eq_len_chk: assert property (@(posedge clk) disable iff (rst)
        (vd.eq && !vd.bad) |-> ((len_a == len_b) || (len_a >= LW'(N) && len_b >= LW'(N))));

    // R3
    empty_low_chk: assert property (@(posedge clk) disable iff (rst)
        (len_a == '0 && len_b != '0 && !vd.bad) |-> vd.lt);

    // R7
    empty_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (len_a == '0 && len_b == '0) |-> (!vd.bad && vd.eq));

endmodule

// File: tb/lexcmp_top_tb.sv
module lexcmp_top_tb;

    localparam int N  = 8;
    localparam int LW = 4;
    localparam int VW = 32;

    typedef struct packed {
        logic [3:0]    la;
        logic [3:0]    lb;
        logic [VW-1:0] va;
        logic [VW-1:0] vb;
        logic [3:0]    exp;   // {lt, eq, gt, bad}
        logic [7:0]    tag;
    } row_t;

    localparam int NROWS = 16;
    localparam row_t ROWS [NROWS] = '{
        '{4'd1, 4'd1, 32'h0000_0000, 32'h1000_0000, 4'b1000, 8'd1},  // R1 U below X
        '{4'd1, 4'd1, 32'h5000_0000, 32'h3000_0000, 4'b0010, 8'd1},  // R1 L above '1'
        '{4'd1, 4'd1, 32'h8000_0000, 32'h7000_0000, 4'b0010, 8'd1},  // R1 don't-care above Z
        '{4'd3, 4'd3, 32'h3280_0000, 32'h3400_0000, 4'b1000, 8'd2},  // R2 position 1 decides
        '{4'd3, 4'd4, 32'h2230_0000, 32'h2234_0000, 4'b1000, 8'd3},  // R3 prefix is lower
        '{4'd4, 4'd3, 32'h2234_0000, 32'h2230_0000, 4'b0010, 8'd3},  // R3 mirrored
        '{4'd2, 4'd3, 32'h3300_0000, 32'h3230_0000, 4'b0010, 8'd4},  // R4 "11" above "101"
        '{4'd4, 4'd5, 32'h3222_0000, 32'h2322_2000, 4'b0010, 8'd4},  // R4 shorter wins early
        '{4'd8, 4'd8, 32'h0123_4567, 32'h0123_4567, 4'b0100, 8'd5},  // R5 full-length equal
        '{4'd0, 4'd0, 32'hFFFF_FFFF, 32'h1234_5678, 4'b0100, 8'd5},  // R5 both empty, junk beyond
        '{4'd2, 4'd3, 32'h2300_0000, 32'h2300_0000, 4'b1000, 8'd3},  // R3 extra U still longer
        '{4'd2, 4'd2, 32'h3200_0000, 32'h32FF_FFFF, 4'b0100, 8'd6},  // R6 junk beyond length
        '{4'd15,4'd8, 32'h4444_4444, 32'h4444_4444, 4'b0100, 8'd6},  // R6 length above N
        '{4'd3, 4'd3, 32'h3290_0000, 32'h3200_0000, 4'b0001, 8'd7},  // R7 code 9 inside
        '{4'd8, 4'd8, 32'h2222_2222, 32'h2222_222A, 4'b0001, 8'd7},  // R7 last slot illegal
        '{4'd8, 4'd8, 32'h3232_2233, 32'h3232_2323, 4'b1000, 8'd9}   // R9 0xA3 below 0xA5
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [LW-1:0] len_a, len_b;
    logic [VW-1:0] vec_a, vec_b;
    logic          lt, eq, gt, bad;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    always #10 clk = ~clk;

    lexcmp_top #(.N(N), .REG_OUT(1'b1)) u_dut (
        .clk(clk), .rst(rst), .len_a(len_a), .len_b(len_b),
        .vec_a(vec_a), .vec_b(vec_b), .lt(lt), .eq(eq), .gt(gt), .bad(bad)
    );

    task automatic check(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {lt, eq, gt, bad};
        checks++;
        if (exp[0] ? (bad !== 1'b1) : (act !== exp)) begin
            errors++;
            $display("FAIL %s actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] la, input logic [3:0] lb,
                         input logic [VW-1:0] va, input logic [VW-1:0] vb);
        len_a = la; len_b = lb; vec_a = va; vec_b = vb;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10 reset state while inputs would give lt
        drive(4'd1, 4'd1, 32'h0000_0000, 32'h1000_0000);
        repeat (3) @(negedge clk);
        check("R10 reset", 4'b0100);
        rst = 1'b0;

        for (int i = 0; i < NROWS; i++) begin
            @(negedge clk);
            drive(ROWS[i].la, ROWS[i].lb, ROWS[i].va, ROWS[i].vb);
            @(negedge clk);
            check($sformatf("R%0d row %0d", ROWS[i].tag, i), ROWS[i].exp);
        end

        // R9 four-bit binary 1000 above 0111
        drive(4'd4, 4'd4, 32'h3222_0000, 32'h2333_0000);
        @(negedge clk);
        check("R9 1000 vs 0111", 4'b0010);

        // R10 one edge of latency
        drive(4'd2, 4'd2, 32'h2200_0000, 32'h2200_0000);
        @(negedge clk);
        check("R10 settle eq", 4'b0100);
        drive(4'd2, 4'd2, 32'h3200_0000, 32'h2200_0000);
        #5;
        check("R10 hold before edge", 4'b0100);
        @(negedge clk);
        check("R10 after edge", 4'b0010);

        // R8 empty versus non-empty
        drive(4'd0, 4'd1, 32'h0000_0000, 32'h0000_0000);
        @(negedge clk);
        check("R8 empty below U", 4'b1000);

        // R10 reset mid-run
        rst = 1'b1;
        @(negedge clk);
        check("R10 reset mid-run", 4'b0100);
        rst = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule